// File: doc/BRIEF.md
# Host Clock Presence Power Monitor

This block decides whether a host system is powered by watching the host's own clock. The local logic runs from a faster reference oscillator and may be alive while the host is switched off. The host clock is brought into the reference domain through a synchronizer. The length of every high phase and every low phase is then measured in reference cycles. A phase that is too short or too long is a fault, because it indicates a wrong frequency or a distorted duty cycle. A host clock that stops toggling is also a fault, and it is caught by a saturating timeout.

The block drives a bus output-enable that gates every signal the local logic sends onto the host expansion bus. On any fault the enable drops in the same reference cycle. It comes back only after a parameterised run of consecutive well-formed host clock periods. The default settings target a host clock of about 7.8 MHz sampled by a reference of 25 MHz or more. All bounds and counts are parameters.

Top module: `hostclk_power_monitor`

## Requirements
- R1: While reset is asserted, and after reset for as long as no host clock toggles, `pwr_good` and `bus_oe` are both 0.
- R2: A completed high phase of the synchronized host clock is accepted only if its length in reference cycles lies in [MIN_HIGH, MAX_HIGH]. Any other length is a fault.
- R3: A completed low phase is accepted only if its length lies in [MIN_LOW, MAX_LOW]. Any other length is a fault.
- R4: If the host clock input holds one level, `bus_oe` is still 1 at the TIMEOUT+1-th rising reference edge after the input changed and is 0 from the TIMEOUT+2-th edge on. This delay is two synchronizer stages plus TIMEOUT cycles.
- R5: `bus_oe` falls in the cycle in which a fault is detected. `pwr_good` falls one reference cycle later.
- R6: After reset or after any fault, `pwr_good` rises only once GOOD_PERIODS consecutive host periods have been measured good. The partial first phase seen after reset is not measured.
- R7: `bus_oe` is never 1 while `pwr_good` is 0.
- R8: After a fault, a renewed stream of good host periods brings `pwr_good` and `bus_oe` back to 1 without a reset.
- R9: A single bad phase inside an otherwise good stream clears `pwr_good`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst | input | 1 | Synchronous active-high reset |
| host_clk | input | 1 | Asynchronous host clock being monitored |
| pwr_good | output | 1 | Host power judged present |
| bus_oe | output | 1 | Output-enable for all host bus drivers |

## Verification
The bench sweeps every pair of high and low phase lengths from one to six reference cycles. A design with an off-by-one bound would accept a one-cycle glitch or reject a legal duty cycle. Stall timing is checked to the exact reference edge: a timeout counter that is one short or one long moves the drop of `bus_oe` by one cycle, and a registered enable lags `pwr_good` in the wrong order. Recovery after a stall, and a single long phase inside a good stream, expose qualification counters that fail to clear or that count the unmeasured first phase.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  // length inside an inclusive window
  function automatic logic in_window(input int len, input int lo, input int hi);
    return (len >= lo) && (len <= hi);
  endfunction

  // increment that stops at a ceiling
  function automatic int sat_inc(input int v, input int ceil_v);
    return (v >= ceil_v) ? ceil_v : v + 1;
  endfunction
endpackage

// File: rtl/hpm_sync.sv
module hpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hpm_phase_meter.sv
module hpm_phase_meter
  import hpm_pkg::*;
#(
  parameter int TIMEOUT  = 16,
  parameter int MIN_HIGH = 1,
  parameter int MAX_HIGH = 3,
  parameter int MIN_LOW  = 1,
  parameter int MAX_LOW  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,          // synchronized host clock
  output logic bad_phase,    // completed phase out of bounds
  output logic stall,        // no edge for TIMEOUT cycles
  output logic good_period   // low phase ended in bounds, measuring armed
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          lvl_q;
  logic          armed_q;
  logic [CW-1:0] run_q;
  logic          toggled, high_done, low_done;
  logic          high_ok, low_ok;

  assign toggled   = lvl ^ lvl_q;
  assign high_done = toggled & ~lvl;
  assign low_done  = toggled &  lvl;
  assign high_ok   = in_window(int'(run_q), MIN_HIGH, MAX_HIGH);
  assign low_ok    = in_window(int'(run_q), MIN_LOW, MAX_LOW);

  assign bad_phase   = armed_q & ((high_done & ~high_ok) | (low_done & ~low_ok));
  assign stall       = ~toggled & (int'(run_q) >= TIMEOUT);
  assign good_period = armed_q & low_done & low_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= 1'b0;
      armed_q <= 1'b0;
      run_q   <= '0;
    end else begin
      lvl_q <= lvl;
      if (toggled) begin
        armed_q <= 1'b1;
        run_q   <= CW'(1);
      end else begin
        run_q <= CW'(sat_inc(int'(run_q), TIMEOUT));
      end
    end
  end
endmodule

// File: rtl/hpm_qualifier.sv
module hpm_qualifier
  import hpm_pkg::*;
#(
  parameter int GOOD_PERIODS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fault,
  input  logic good_period,
  output logic qualified
);
  localparam int GW = $clog2(GOOD_PERIODS + 1);

  logic [GW-1:0] streak_q;

  always_ff @(posedge clk) begin
    if (rst || fault)      streak_q <= '0;
    else if (good_period)  streak_q <= GW'(sat_inc(int'(streak_q), GOOD_PERIODS));
  end

  assign qualified = (int'(streak_q) == GOOD_PERIODS);
endmodule

// File: rtl/hostclk_power_monitor.sv
module hostclk_power_monitor #(
  parameter int SYNC_STAGES  = 2,
  parameter int TIMEOUT      = 16,
  parameter int MIN_HIGH     = 1,
  parameter int MAX_HIGH     = 3,
  parameter int MIN_LOW      = 1,
  parameter int MAX_LOW      = 3,
  parameter int GOOD_PERIODS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic host_clk,
  output logic pwr_good,
  output logic bus_oe
);
  logic host_lvl;
  logic bad_phase_w, stall_w, fault_w, good_period_w;

  hpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(host_clk), .q(host_lvl)
  );

  hpm_phase_meter #(
    .TIMEOUT(TIMEOUT), .MIN_HIGH(MIN_HIGH), .MAX_HIGH(MAX_HIGH),
    .MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW)
  ) u_meter (
    .clk(clk), .rst(rst), .lvl(host_lvl),
    .bad_phase(bad_phase_w), .stall(stall_w), .good_period(good_period_w)
  );

  assign fault_w = bad_phase_w | stall_w;

  hpm_qualifier #(.GOOD_PERIODS(GOOD_PERIODS)) u_qual (
    .clk(clk), .rst(rst), .fault(fault_w), .good_period(good_period_w),
    .qualified(pwr_good)
  );

  assign bus_oe = pwr_good & ~fault_w;
endmodule

// File: rtl/hpm_checker.sv
module hpm_checker (
  input logic clk,
  input logic rst,
  input logic pwr_good,
  input logic bus_oe,
  input logic fault_w,
  input logic stall_w,
  input logic good_period_w
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !pwr_good && !bus_oe);
  a_r7_oe_needs_good: assert property (@(posedge clk) disable iff (rst) bus_oe |-> pwr_good);
  a_r4_stall_blocks_oe: assert property (@(posedge clk) disable iff (rst) stall_w |-> !bus_oe);
  a_r5_fault_drops_good: assert property (@(posedge clk) disable iff (rst) fault_w |=> !pwr_good);
  a_r6_rise_after_good_period: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_good) |-> $past(good_period_w));
endmodule

bind hostclk_power_monitor hpm_checker u_chk (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .bus_oe(bus_oe),
  .fault_w(fault_w), .stall_w(stall_w), .good_period_w(good_period_w)
);

// File: tb/test_hostclk_power_monitor.sv
module test_hostclk_power_monitor;
  localparam int TO = 16, MINH = 2, MAXH = 4, MINL = 2, MAXL = 5, GP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_clk = 1'b0;
  logic pwr_good, bus_oe;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hostclk_power_monitor #(
    .SYNC_STAGES(2), .TIMEOUT(TO), .MIN_HIGH(MINH), .MAX_HIGH(MAXH),
    .MIN_LOW(MINL), .MAX_LOW(MAXL), .GOOD_PERIODS(GP)
  ) i_hostclk_power_monitor (
    .clk(clk), .rst(rst), .host_clk(host_clk), .pwr_good(pwr_good), .bus_oe(bus_oe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one host period; called and returns at a falling ref edge
  task automatic period(input int h, input int l);
    host_clk = 1'b1;
    repeat (h) @(negedge clk);
    host_clk = 1'b0;
    repeat (l) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    host_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (TO + 4) @(negedge clk);
  endtask

  function automatic bit shape_ok(input int h, input int l);
    return (h >= MINH) && (h <= MAXH) && (l >= MINL) && (l <= MAXL);
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset pwr_good", pwr_good, 1'b0);
    check("R1 reset bus_oe", bus_oe, 1'b0);
    do_reset();
    check("R1 idle pwr_good", pwr_good, 1'b0);
    check("R1 idle bus_oe", bus_oe, 1'b0);

    // R2 / R3 sweep of phase shapes
    for (int h = 1; h <= 6; h++) begin
      for (int l = 1; l <= 6; l++) begin
        do_reset();
        repeat (GP - 1) period(h, l);
        check($sformatf("R6 early h%0d l%0d", h, l), pwr_good, 1'b0);
        repeat (4) period(h, l);
        check($sformatf("R2 R3 pg h%0d l%0d", h, l), pwr_good, shape_ok(h, l));
        check($sformatf("R7 oe h%0d l%0d", h, l), bus_oe, shape_ok(h, l));
      end
    end

    // R4 / R5 stall timing on a qualified stream
    do_reset();
    repeat (GP + 4) period(3, 3);
    check("R6 qualified", pwr_good, 1'b1);
    host_clk = 1'b1;
    for (int m = 1; m <= TO + 3; m++) begin
      @(negedge clk);
      if (m == TO + 1) check("R4 oe still on", bus_oe, 1'b1);
      if (m == TO + 2) begin
        check("R4 oe off at timeout", bus_oe, 1'b0);
        check("R5 pg lags oe", pwr_good, 1'b1);
      end
      if (m == TO + 3) check("R5 pg off", pwr_good, 1'b0);
    end
    host_clk = 1'b0;
    repeat (4) @(negedge clk);

    // R8 recovery without reset
    repeat (GP + 4) period(2, 5);
    check("R8 recovered pg", pwr_good, 1'b1);
    check("R8 recovered oe", bus_oe, 1'b1);

    // R9 single long high phase
    period(MAXH + 1, 3);
    check("R9 bad phase clears pg", pwr_good, 1'b0);
    check("R9 bad phase clears oe", bus_oe, 1'b0);
    repeat (GP - 2) period(4, 2);
    check("R6 requalify early", pwr_good, 1'b0);
    repeat (4) period(4, 2);
    check("R8 requalify", pwr_good, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule